// File: doc/BRIEF.md
# Quadrant-Tree Uniformity Flag Builder

This block watches a Z-order scan of a square array of quantized pixel codes, 2^K pixels on a side. It keeps one flag for every node of the quadrant tree above the pixels. A node covers a square block of 2×2, 4×4 and so on, up to the whole array at the root. The flag of a node stays at 1 while every pixel under it is uniform. Every tree layer is updated in the same cycle, and the node in each layer is picked from the upper bits of the scan address. With codes of two or more bits, uniform means equal codes. With a 1-bit oscillating quantizer, uniform means codes that alternate on every pixel.

When the build phase ends, the whole tree is trimmed in one clock, so that only the highest compressible nodes keep their flags. A read request then sends the flags out one bit per cycle and ends with a done strobe. During a second readout of the array, a combinational skip output marks every address that a surviving flag covers, so that those pixels can be left out.

Top module: `qtree_flag_builder`

## Requirements
- R1: After reset every flag is 1, `flag_vld` and `flag_done` are 0, and `skip` is 1 for every address.
- R2: On a clock where `construct` is 1 and was 0 on the clock before, every flag is set back to 1.
- R3: With `CODE_W` > 1, while `construct` stays 1, a valid pixel whose code differs from the previous valid code clears the flag of each layer-l node (l = 1..K, node number = scan_addr >> 2l) whose block it is not the first pixel of. Equal codes leave all flags unchanged, and a flag never goes from 0 back to 1 during the build.
- R4: With `CODE_W` = 1, the rule is inverted: a valid code equal to the previous valid code clears the node flags as in R3, and a code that alternates leaves them unchanged.
- R5: A pixel whose address has its low 2l bits all zero (the first pixel of a layer-l block) is never compared for that layer, so a change of code at a block boundary leaves that block's flag set.
- R6: On the clock where `construct` falls from 1 to 0, every flag that has an ancestor flag at 1 is cleared in that one clock. Flags without a set ancestor keep their value.
- R7: A `flag_rd` pulse while idle starts a stream of (4^K-1)/3 bits on `flag_bit`, with `flag_vld` high. The first bit appears after the next clock edge. The root comes first, then the layers from K-1 down to 1, and each layer is sent in ascending node number (Z order).
- R8: `flag_done` is high for exactly one cycle, in the cycle right after the last streamed bit, and `flag_vld` is 0 in that cycle.
- R9: `skip` is 1 exactly when some layer l in 1..K has the flag of node scan_addr >> 2l set. It is combinational from `scan_addr`.
- R10: A `flag_rd` pulse while a stream is running has no effect on the stream.
- R11: Cycles with `scan_vld` = 0 neither compare a code nor replace the stored previous code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_vld | input | 1 | Pixel strobe |
| scan_addr | input | 2*K | Z-order pixel address, also the skip lookup address |
| scan_code | input | CODE_W | Quantized code of the pixel |
| construct | input | 1 | 1 = build phase. A rising edge re-initializes the flags and a falling edge trims the tree |
| flag_rd | input | 1 | Start the serial flag stream |
| flag_bit | output | 1 | Serial flag data |
| flag_vld | output | 1 | `flag_bit` holds a valid flag |
| flag_done | output | 1 | One-cycle strobe after the last flag |
| skip | output | 1 | Pixel at `scan_addr` is covered by a set flag |

## Verification
The hardest case to reach is a tree whose surviving flags sit at different layers in different branches. This case is the only one that shows trimming and the block-start exemption at the same time. The stimulus builds images whose codes change exactly on block boundaries: quadrant-constant images and, in 1-bit mode, alternating patterns whose phase flips at every 2×2 block start. It also uses mixed images, in which uniform quadrants sit next to noisy ones. Two instances, one per comparison rule, share the address, strobe and control stimulus, and a bench model of each image predicts the streamed flags and the skip map.

// File: rtl/qtree_pkg.sv
package qtree_pkg;
    // Base index of layer l in a flag vector laid out root first, breadth first
    function automatic int lyr_off(int k, int l);
        return ((1 << (2 * (k - l))) - 1) / 3;
    endfunction

    // Total number of tree nodes above the pixels
    function automatic int node_count(int k);
        return ((1 << (2 * k)) - 1) / 3;
    endfunction
endpackage

// File: rtl/qt_pair_cmp.sv
module qt_pair_cmp #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              brk_o
);
    typedef struct packed {
        logic [CODE_W-1:0] prev;
    } st_t;

    st_t st_d, st_q;
    logic rule_hit;

    generate
        if (CODE_W == 1) begin : g_osc
            // oscillating quantizer: a repeated code breaks uniformity
            assign rule_hit = ~(code_i ^ st_q.prev);
        end else begin : g_eq
            assign rule_hit = (code_i != st_q.prev);
        end
    endgenerate

    assign brk_o = vld_i & rule_hit;

    always_comb begin
        st_d = st_q;
        if (vld_i) st_d.prev = code_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/qt_flag_store.sv
module qt_flag_store
    import qtree_pkg::*;
#(
    parameter int K  = 4,
    parameter int NF = node_count(K),
    parameter int AW = 2 * K
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [AW-1:0] addr_i,
    input  logic          brk_i,
    input  logic          con_i,
    output logic [NF-1:0] flags_o
);
    typedef struct packed {
        logic [NF-1:0] flags;
        logic          con;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [NF-1:0] cov;
        logic [NF-1:0] trm;
        st_d     = st_q;
        st_d.con = con_i;
        cov      = '0;
        trm      = '0;
        cov[0]   = st_q.flags[0];
        trm[0]   = st_q.flags[0];
        for (int i = 1; i < NF; i++) begin
            cov[i] = st_q.flags[i] | cov[(i - 1) >> 2];
            trm[i] = st_q.flags[i] & ~cov[(i - 1) >> 2];
        end
        if (con_i && !st_q.con) begin
            st_d.flags = '1;
        end else if (!con_i && st_q.con) begin
            st_d.flags = trm;
        end else if (con_i && vld_i && brk_i) begin
            for (int l = 1; l <= K; l++) begin
                if ((addr_i & AW'((1 << (2 * l)) - 1)) != '0)
                    st_d.flags[lyr_off(K, l) + int'(addr_i >> (2 * l))] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= '1;
            st_q.con   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

    assert_reinit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (con_i && !st_q.con) |=> (&st_q.flags));

    assert_build_only_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (con_i && st_q.con) |=> ((st_q.flags & ~$past(st_q.flags)) == '0));

    assert_trim_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!con_i && st_q.con) |=> ((st_q.flags & ~$past(st_q.flags)) == '0));
endmodule

// File: rtl/qt_serializer.sv
module qt_serializer #(
    parameter int NF = 85,
    parameter int IW = (NF > 1) ? $clog2(NF) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_i,
    input  logic [NF-1:0] flags_i,
    output logic          bit_o,
    output logic          vld_o,
    output logic          done_o
);
    typedef struct packed {
        logic          active;
        logic [IW-1:0] ptr;
        logic          done;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.active) begin
            if (rd_i) begin
                st_d.active = 1'b1;
                st_d.ptr    = '0;
            end
        end else if (st_q.ptr == IW'(NF - 1)) begin
            st_d.active = 1'b0;
            st_d.done   = 1'b1;
        end else begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_o  = flags_i[st_q.ptr];
    assign vld_o  = st_q.active;
    assign done_o = st_q.done;

    assert_done_ends_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vld_o) |-> done_o);

    assert_done_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_rd_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && rd_i && st_q.ptr != IW'(NF - 1)) |=> (vld_o && st_q.ptr == $past(st_q.ptr) + 1'b1));
endmodule

// File: rtl/qtree_flag_builder.sv
module qtree_flag_builder
    import qtree_pkg::*;
#(
    parameter int K      = 4,
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_vld,
    input  logic [2*K-1:0]    scan_addr,
    input  logic [CODE_W-1:0] scan_code,
    input  logic              construct,
    input  logic              flag_rd,
    output logic              flag_bit,
    output logic              flag_vld,
    output logic              flag_done,
    output logic              skip
);
    localparam int NF = node_count(K);
    localparam int AW = 2 * K;

    logic          brk;
    logic [NF-1:0] flags;

    qt_pair_cmp #(.CODE_W(CODE_W)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (scan_vld),
        .code_i (scan_code),
        .brk_o  (brk)
    );

    qt_flag_store #(.K(K), .NF(NF), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (scan_vld),
        .addr_i  (scan_addr),
        .brk_i   (brk),
        .con_i   (construct),
        .flags_o (flags)
    );

    qt_serializer #(.NF(NF)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (flag_rd),
        .flags_i (flags),
        .bit_o   (flag_bit),
        .vld_o   (flag_vld),
        .done_o  (flag_done)
    );

    always_comb begin
        skip = 1'b0;
        for (int l = 1; l <= K; l++)
            skip = skip | flags[lyr_off(K, l) + int'(scan_addr >> (2 * l))];
    end
endmodule

// File: tb/tb_qtree_flag_builder.sv
module tb_qtree_flag_builder;
    localparam int K          = 3;
    localparam int P          = 1 << (2 * K);
    localparam int NF         = (P - 1) / 3;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic vld, con, rd;
    logic [2*K-1:0] addr;
    logic [1:0] code2;
    logic [0:0] code1;
    logic bit2, vld2, done2, skip2;
    logic bit1, vld1, done1, skip1;

    int checks = 0;
    int fails  = 0;

    logic [1:0] img2 [P];
    logic       img1 [P];
    logic       exp2 [NF];
    logic       exp1 [NF];

    always #(CLK_PERIOD / 2) clk = ~clk;

    qtree_flag_builder #(.K(K), .CODE_W(2)) dut (
        .clk(clk), .rst_n(rst_n), .scan_vld(vld), .scan_addr(addr), .scan_code(code2),
        .construct(con), .flag_rd(rd), .flag_bit(bit2), .flag_vld(vld2),
        .flag_done(done2), .skip(skip2)
    );

    qtree_flag_builder #(.K(K), .CODE_W(1)) dut_osc (
        .clk(clk), .rst_n(rst_n), .scan_vld(vld), .scan_addr(addr), .scan_code(code1),
        .construct(con), .flag_rd(rd), .flag_bit(bit1), .flag_vld(vld1),
        .flag_done(done1), .skip(skip1)
    );

    task automatic chk(string req, string what, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, expv);
        end
    endtask

    function automatic int offb(int l);
        return ((1 << (2 * (K - l))) - 1) / 3;
    endfunction

    // Bench model: raw uniformity per node, then ancestor trimming
    function automatic void build_exp();
        logic raw2 [NF];
        logic raw1 [NF];
        for (int l = 1; l <= K; l++) begin
            for (int n = 0; n < (1 << (2 * (K - l))); n++) begin
                logic u2 = 1'b1;
                logic u1 = 1'b1;
                for (int j = 1; j < (1 << (2 * l)); j++) begin
                    int p = n * (1 << (2 * l)) + j;
                    if (img2[p] != img2[p - 1]) u2 = 1'b0;
                    if (img1[p] == img1[p - 1]) u1 = 1'b0;
                end
                raw2[offb(l) + n] = u2;
                raw1[offb(l) + n] = u1;
            end
        end
        for (int i = 0; i < NF; i++) begin
            logic a2 = 1'b0;
            logic a1 = 1'b0;
            int q = i;
            while (q > 0) begin
                q = (q - 1) / 4;
                a2 = a2 | raw2[q];
                a1 = a1 | raw1[q];
            end
            exp2[i] = raw2[i] & ~a2;
            exp1[i] = raw1[i] & ~a1;
        end
    endfunction

    function automatic logic skip_model(int a, bit osc);
        logic s = 1'b0;
        for (int l = 1; l <= K; l++)
            s = s | (osc ? exp1[offb(l) + (a >> (2 * l))] : exp2[offb(l) + (a >> (2 * l))]);
        return s;
    endfunction

    // Build phase: rising construct, scan, falling construct (trim)
    task automatic run_scan(bit gaps);
        @(negedge clk);
        con = 1'b1; vld = 1'b0;
        @(negedge clk);
        for (int a = 0; a < P; a++) begin
            vld = 1'b1; addr = a[2*K-1:0]; code2 = img2[a]; code1 = img1[a];
            @(negedge clk);
            if (gaps && (a % 3 == 1)) begin
                // R11: garbage that would break both rules if it were compared
                vld = 1'b0; code2 = img2[a] ^ 2'b01; code1 = img1[a];
                addr = a[2*K-1:0] ^ 6'b000001;
                @(negedge clk);
            end
        end
        vld = 1'b0;
        con = 1'b0;
        @(negedge clk);
    endtask

    // Read the stream and compare with the model (R7, R8, optional R10 pulse)
    task automatic read_stream(string req, bit poke);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        for (int i = 0; i < NF; i++) begin
            chk("R7", $sformatf("%s vld2 bit %0d", req, i), vld2, 1'b1);
            chk(req, $sformatf("flag2[%0d]", i), bit2, exp2[i]);
            chk(req, $sformatf("flag1[%0d]", i), bit1, exp1[i]);
            rd = (poke && i == 4) ? 1'b1 : 1'b0;
            @(negedge clk);
            rd = 1'b0;
        end
        chk("R8", "vld low after stream", vld2, 1'b0);
        chk("R8", "done2 strobe", done2, 1'b1);
        chk("R8", "done1 strobe", done1, 1'b1);
        @(negedge clk);
        chk("R8", "done2 one cycle", done2, 1'b0);
        chk("R10", "no restart", vld2, 1'b0);
    endtask

    task automatic sweep_skip(string req);
        for (int a = 0; a < P; a++) begin
            addr = a[2*K-1:0];
            #1;
            chk("R9", $sformatf("%s skip2 addr %0d", req, a), skip2, skip_model(a, 1'b0));
            chk("R9", $sformatf("%s skip1 addr %0d", req, a), skip1, skip_model(a, 1'b1));
        end
    endtask

    task automatic t_reset();
        addr = '0;
        #1;
        chk("R1", "vld2 after reset", vld2, 1'b0);
        chk("R1", "done2 after reset", done2, 1'b0);
        for (int a = 0; a < P; a += 9) begin
            addr = a[2*K-1:0];
            #1;
            chk("R1", $sformatf("skip after reset addr %0d", a), skip2 & skip1, 1'b1);
        end
    endtask

    task automatic t_uniform();
        for (int a = 0; a < P; a++) begin img2[a] = 2'd2; img1[a] = a[0]; end
        build_exp();
        run_scan(1'b0);
        read_stream("R3_R4_R6", 1'b1);
        sweep_skip("uniform");
    endtask

    task automatic t_quadrants();
        for (int a = 0; a < P; a++) begin
            img2[a] = 2'(a >> 4);
            img1[a] = a[0] ^ a[2];
        end
        build_exp();
        run_scan(1'b0);
        read_stream("R5_R6", 1'b0);
        sweep_skip("quadrants");
    endtask

    task automatic t_mixed();
        for (int a = 0; a < P; a++) begin
            img2[a] = (a < 16) ? 2'd1 : (a < 48) ? ((a % 7 == 0) ? 2'd3 : 2'd0) : 2'(a);
            img1[a] = (a < 32) ? a[0] : ((a % 5) == 0);
        end
        build_exp();
        run_scan(1'b0);
        read_stream("R3_R4", 1'b0);
        sweep_skip("mixed");
    endtask

    task automatic t_gaps();
        for (int a = 0; a < P; a++) begin img2[a] = 2'd0; img1[a] = ~a[0]; end
        build_exp();
        run_scan(1'b1);
        read_stream("R11", 1'b0);
    endtask

    task automatic t_reinit();
        // flags hold a cleared tree from the mixed image; a rising edge must refill them
        @(negedge clk);
        con = 1'b1;
        @(negedge clk);
        con = 1'b0;
        @(negedge clk);
        for (int i = 0; i < NF; i++) begin exp2[i] = (i == 0); exp1[i] = (i == 0); end
        read_stream("R2", 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; vld = 1'b0; con = 1'b0; rd = 1'b0;
        addr = '0; code2 = '0; code1 = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_uniform();
        t_quadrants();
        t_mixed();
        t_reinit();
        t_gaps();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule